// File: doc/BRIEF.md
# Auto-scrolling pattern sequencer

This block picks the index of the test pattern that a video pattern generator draws in the next frame. It does not make pixels. It only decides which pattern is shown and when that choice changes. All decisions are made on a frame-start pulse, so one frame always carries a single pattern.

With scrolling off, the block shows a fixed index taken from a control input. With scrolling on, it walks a programmable list of up to sixteen 5-bit pattern indices and shows each entry for a programmable number of frames. At the end of the list it wraps back to the first entry. List entries that must not be scrolled are skipped without spending a frame on them: the colour-bar code and any out-of-range code. The same index may appear any number of times, in any order.

Top module: `pat_scroll_seq`

## Requirements
- R1: After reset, `pat_o` is 0 and `pat_valid_o` is 0.
- R2: `pat_o` and `pat_valid_o` change only in the cycle after a clock edge that sampled `frame_start_i` high. At all other times they hold, whatever the other inputs do.
- R3: On a frame start with `scroll_en_i` low, `pat_o` takes `static_pat_i`. `pat_valid_o` is 1 exactly when `static_pat_i` is below 18. Code 17, the colour bar, is allowed here.
- R4: A frame start with `scroll_en_i` high restarts the list at entry 0 with a fresh dwell, but only if the previous frame start had it low or there was none since reset. Toggling `scroll_en_i` between two frame starts has no effect.
- R5: Each shown entry stays for D frame starts, where D is `dwell_i` and a `dwell_i` of 0 counts as 1. `dwell_i` is sampled when the entry is loaded.
- R6: The list length L is `seq_len_i`, with 0 read as 1 and values above 16 read as 16. Entry k sits in `seq_list_i[5k+4:5k]`. After entry L-1 the next entry searched is entry 0.
- R7: A list entry equal to 17 (colour bar) or above 17 is skipped. The next legal entry in list order, wrapping at L, is shown at the same frame start. In scroll mode a valid output is never 17.
- R8: Entries may repeat, and adjacent equal entries are each shown for their own full dwell.
- R9: In scroll mode, if no legal entry is found within L entries, `pat_o` is 0 and `pat_valid_o` is 0. Each later frame start searches again from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse at the start of each frame |
| scroll_en_i | input | 1 | 1 = scroll through the list, 0 = static index |
| static_pat_i | input | 5 | Pattern index used when scrolling is off |
| seq_len_i | input | 5 | Number of list entries in use |
| seq_list_i | input | 80 | Sixteen 5-bit list entries, entry k at bits 5k+4:5k |
| dwell_i | input | 8 | Frames per entry (0 read as 1) |
| pat_o | output | 5 | Current pattern index |
| pat_valid_o | output | 1 | Current index is a legal pattern |

## Verification
The bench aims at a colour-bar entry placed between two copies of the same pattern. A sequencer that spends a frame on the skipped entry, or that merges the repeats, shows the wrong index or a wrong number of frames. It drives a length of 0, a length above 16 and a zero dwell, where a design without the clamps would index past the list or stall on one entry. It lowers and raises the enable mid-sequence, both between frame starts and across one, to catch a restart that fires at the wrong time. It also fills the list with only illegal codes and then repairs one, to check that the sequencer drops the valid flag and recovers at the next frame.

// File: rtl/pat_seq_pkg.sv
package pat_seq_pkg;
  localparam int IDX_W = 5;
  typedef logic [IDX_W-1:0] pat_idx_t;

  // pattern may appear in a scrolling list
  function automatic logic scroll_legal(pat_idx_t idx, int num_pat, int cbar_idx);
    return (int'(idx) < num_pat) && (int'(idx) != cbar_idx);
  endfunction
endpackage

// File: rtl/seq_entry_finder.sv
module seq_entry_finder
  import pat_seq_pkg::*;
#(
  parameter int N_ENT        = 16,
  parameter int NUM_PAT      = 18,
  parameter int COLORBAR_IDX = 17,
  localparam int POS_W = $clog2(N_ENT),
  localparam int LEN_W = $clog2(N_ENT + 1)
) (
  input  logic [N_ENT*IDX_W-1:0] list_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [POS_W-1:0]       start_i,
  output logic                   found_o,
  output logic [POS_W-1:0]       pos_o,
  output pat_idx_t               idx_o
);
  pat_idx_t         ents     [N_ENT];
  pat_idx_t         cand_idx [N_ENT];
  logic [POS_W-1:0] cand_pos [N_ENT];
  logic [N_ENT-1:0] cand_ok;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    assign ents[e] = list_i[e*IDX_W +: IDX_W];
  end

  // candidate k = entry (start + k) mod len
  for (genvar k = 0; k < N_ENT; k++) begin : g_cand
    logic [LEN_W:0] sum;
    logic [LEN_W:0] wrapped;
    assign sum         = (LEN_W+1)'(start_i) + (LEN_W+1)'(k);
    assign wrapped     = (sum >= {1'b0, len_i}) ? sum - {1'b0, len_i} : sum;
    assign cand_pos[k] = wrapped[POS_W-1:0];
    assign cand_idx[k] = ents[wrapped[POS_W-1:0]];
    assign cand_ok[k]  = ((LEN_W+1)'(k) < {1'b0, len_i}) &&
                         scroll_legal(cand_idx[k], NUM_PAT, COLORBAR_IDX);
  end

  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    idx_o   = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (cand_ok[k]) begin
        found_o = 1'b1;
        pos_o   = cand_pos[k];
        idx_o   = cand_idx[k];
      end
    end
  end
endmodule

// File: rtl/seq_dwell_ctr.sv
module seq_dwell_ctr #(
  parameter int DWELL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               tick_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic               expire_o
);
  logic [DWELL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (dwell_i == '0) ? '0 : dwell_i - DWELL_W'(1);
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - DWELL_W'(1);
    end
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/pat_scroll_seq.sv
module pat_scroll_seq
  import pat_seq_pkg::*;
#(
  parameter int N_ENT        = 16,
  parameter int DWELL_W      = 8,
  parameter int NUM_PAT      = 18,
  parameter int COLORBAR_IDX = 17,
  localparam int POS_W = $clog2(N_ENT),
  localparam int LEN_W = $clog2(N_ENT + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_start_i,
  input  logic                   scroll_en_i,
  input  logic [IDX_W-1:0]       static_pat_i,
  input  logic [LEN_W-1:0]       seq_len_i,
  input  logic [N_ENT*IDX_W-1:0] seq_list_i,
  input  logic [DWELL_W-1:0]     dwell_i,
  output logic [IDX_W-1:0]       pat_o,
  output logic                   pat_valid_o
);
  logic             mode_q, valid_q;
  pat_idx_t         pat_q;
  logic [POS_W-1:0] pos_q;

  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] pos_inc;
  logic [POS_W-1:0] next_start, search_start;
  logic             found, expire, advance, load, tick;
  logic [POS_W-1:0] f_pos;
  pat_idx_t         f_idx;

  assign eff_len = (seq_len_i == '0)              ? LEN_W'(1) :
                   (seq_len_i > LEN_W'(N_ENT))    ? LEN_W'(N_ENT) : seq_len_i;

  assign pos_inc      = LEN_W'(pos_q) + LEN_W'(1);
  assign next_start   = (pos_inc >= eff_len) ? '0 : pos_inc[POS_W-1:0];
  assign search_start = (mode_q && valid_q) ? next_start : '0;

  seq_entry_finder #(
    .N_ENT(N_ENT), .NUM_PAT(NUM_PAT), .COLORBAR_IDX(COLORBAR_IDX)
  ) u_find (
    .list_i (seq_list_i),
    .len_i  (eff_len),
    .start_i(search_start),
    .found_o(found),
    .pos_o  (f_pos),
    .idx_o  (f_idx)
  );

  // restart when entering scroll mode or recovering from an empty search
  assign advance = frame_start_i && scroll_en_i && (!mode_q || !valid_q || expire);
  assign load    = advance && found;
  assign tick    = frame_start_i && scroll_en_i && mode_q && valid_q && !expire;

  seq_dwell_ctr #(.DWELL_W(DWELL_W)) u_dwell (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .tick_i  (tick),
    .dwell_i (dwell_i),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      valid_q <= 1'b0;
      pat_q   <= '0;
      pos_q   <= '0;
    end else if (frame_start_i) begin
      if (!scroll_en_i) begin
        mode_q  <= 1'b0;
        pat_q   <= static_pat_i;
        valid_q <= (static_pat_i < IDX_W'(NUM_PAT));
      end else if (advance) begin
        mode_q <= 1'b1;
        if (found) begin
          pat_q   <= f_idx;
          pos_q   <= f_pos;
          valid_q <= 1'b1;
        end else begin
          pat_q   <= '0;
          valid_q <= 1'b0;
        end
      end
    end
  end

  assign pat_o       = pat_q;
  assign pat_valid_o = valid_q;
endmodule

// File: rtl/pat_scroll_seq_chk.sv
module pat_scroll_seq_chk #(
  parameter int IDX_W        = 5,
  parameter int NUM_PAT      = 18,
  parameter int COLORBAR_IDX = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_i,
  input logic             scroll_en_i,
  input logic [IDX_W-1:0] static_pat_i,
  input logic [IDX_W-1:0] pat_o,
  input logic             pat_valid_o,
  input logic             mode_i
);
  assert_hold_between_frames_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_start_i) |-> ($stable(pat_o) && $stable(pat_valid_o)));

  assert_static_select_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_start_i && !scroll_en_i) |->
      (pat_o == $past(static_pat_i)) &&
      (pat_valid_o == (int'($past(static_pat_i)) < NUM_PAT)));

  assert_enter_scroll_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_start_i && scroll_en_i) |-> mode_i);

  assert_no_colorbar_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && pat_valid_o) |->
      (int'(pat_o) != COLORBAR_IDX) && (int'(pat_o) < NUM_PAT));

  assert_empty_list_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !pat_valid_o) |-> (pat_o == '0));
endmodule

bind pat_scroll_seq pat_scroll_seq_chk #(
  .IDX_W(pat_seq_pkg::IDX_W), .NUM_PAT(NUM_PAT), .COLORBAR_IDX(COLORBAR_IDX)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .scroll_en_i  (scroll_en_i),
  .static_pat_i (static_pat_i),
  .pat_o        (pat_o),
  .pat_valid_o  (pat_valid_o),
  .mode_i       (mode_q)
);

// File: tb/sim_pat_scroll_seq.sv
`timescale 1ns/1ps
module sim_pat_scroll_seq;
  localparam int N_ENT = 16;

  typedef struct {
    logic [4:0] pat;
    logic       valid;
    string      req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic        en = 1'b0;
  logic [4:0]  stat = '0;
  logic [4:0]  len = 5'd1;
  logic [79:0] list = '0;
  logic [7:0]  dwell = 8'd1;
  logic [4:0]  pat;
  logic        valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  exp_t q[$];
  exp_t cur;
  bit   have_cur = 1'b0;
  logic cmp_due = 1'b0;

  // reference state
  bit         m_mode = 0;
  bit         m_valid = 0;
  int         m_pos = 0;
  int         m_left = 0;
  logic [4:0] m_pat = '0;

  always #2 clk = ~clk;

  pat_scroll_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .scroll_en_i(en),
    .static_pat_i(stat), .seq_len_i(len), .seq_list_i(list), .dwell_i(dwell),
    .pat_o(pat), .pat_valid_o(valid)
  );

  function automatic int eff_len();
    if (len == 0) return 1;
    if (len > N_ENT) return N_ENT;
    return int'(len);
  endfunction

  function automatic bit legal(logic [4:0] v);
    return v < 5'd17;
  endfunction

  function automatic int find(int start);
    int l = eff_len();
    for (int k = 0; k < l; k++) begin
      int p = start + k;
      if (p >= l) p -= l;
      if (legal(list[p*5 +: 5])) return p;
    end
    return -1;
  endfunction

  task automatic set_ent(int k, logic [4:0] v);
    list[k*5 +: 5] = v;
  endtask

  task automatic model_frame();
    int d = (dwell == 0) ? 1 : int'(dwell);
    if (!en) begin
      m_mode = 0; m_pat = stat; m_valid = (stat < 5'd18);
    end else if (!m_mode || !m_valid || m_left == 0) begin
      int st = 0;
      int p;
      if (m_mode && m_valid) st = (m_pos + 1 >= eff_len()) ? 0 : m_pos + 1;
      m_mode = 1;
      p = find(st);
      if (p < 0) begin
        m_pat = '0; m_valid = 0;
      end else begin
        m_pos = p; m_pat = list[p*5 +: 5]; m_valid = 1; m_left = d - 1;
      end
    end else begin
      m_left--;
    end
  endtask

  task automatic frame(string req);
    exp_t e;
    @(negedge clk);
    model_frame();
    e.pat = m_pat; e.valid = m_valid; e.req = req;
    q.push_back(e);
    fs = 1'b1;
    @(negedge clk);
    fs = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) cmp_due <= fs;

  // monitor
  always @(negedge clk) begin
    if (cmp_due) begin
      if (q.size() == 0) begin
        errors++; checks++;
        $display("FAIL R2: output update without expected item, pat=%0d valid=%0d", pat, valid);
      end else begin
        cur = q.pop_front();
        have_cur = 1'b1;
        checks++;
        if (pat !== cur.pat || valid !== cur.valid) begin
          errors++;
          $display("FAIL %s: pat=%0d valid=%0d expected pat=%0d valid=%0d",
                   cur.req, pat, valid, cur.pat, cur.valid);
        end
      end
    end else if (have_cur && rst_n) begin
      checks++;
      if (pat !== cur.pat || valid !== cur.valid) begin
        errors++;
        $display("FAIL R2: held pat=%0d valid=%0d expected pat=%0d valid=%0d",
                 pat, valid, cur.pat, cur.valid);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (pat !== 5'd0 || valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: pat=%0d valid=%0d expected pat=0 valid=0", pat, valid);
    end
    cur.pat = '0; cur.valid = 1'b0; cur.req = "R1";
    have_cur = 1'b1;

    // R3 static selection
    stat = 5'd5;  frame("R3");
    stat = 5'd17; frame("R3");
    stat = 5'd25; frame("R3");
    stat = 5'd3;  repeat (3) @(negedge clk);  // R2: no change until frame start
    frame("R3");

    // R4 R5 R7 R8: list 3,17,3,9 dwell 2
    set_ent(0, 5'd3); set_ent(1, 5'd17); set_ent(2, 5'd3); set_ent(3, 5'd9);
    len = 5'd4; dwell = 8'd2; en = 1'b1;
    for (int i = 0; i < 10; i++) frame("R5_R7_R8");

    // R5 zero dwell = one frame
    dwell = 8'd0;
    for (int i = 0; i < 6; i++) frame("R5");

    // R4 toggle between frame starts: no restart
    dwell = 8'd2;
    frame("R4");
    en = 1'b0; @(negedge clk); en = 1'b1;
    for (int i = 0; i < 3; i++) frame("R4");

    // R4 disable across a frame, then restart at entry 0
    en = 1'b0; frame("R3");
    en = 1'b1;
    for (int i = 0; i < 4; i++) frame("R4");

    // R6 zero length read as one
    len = 5'd0; set_ent(0, 5'd7); dwell = 8'd0;
    for (int i = 0; i < 3; i++) frame("R6");

    // R6 R7 length above 16 clamped, full wrap
    for (int k = 0; k < N_ENT; k++) set_ent(k, 5'((k * 5 + 1) % 20));
    len = 5'd20; dwell = 8'd1;
    for (int i = 0; i < 20; i++) frame("R6_R7");

    // R9 no legal entry, then recovery
    len = 5'd3; set_ent(0, 5'd17); set_ent(1, 5'd20); set_ent(2, 5'd31);
    en = 1'b0; frame("R3");
    en = 1'b1;
    for (int i = 0; i < 3; i++) frame("R9");
    set_ent(1, 5'd2);
    for (int i = 0; i < 3; i++) frame("R9");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R2: %0d expected items not produced, expected 0", q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule